// File: doc/BRIEF.md
# Interrupt Concentrator with Message Delivery

This block collects eleven device interrupt lines into one processor interrupt and delivers that interrupt as a posted bus write: a programmed data word sent to a programmed address. Software controls it through a small register port. The port holds an enable mask, a sticky pending register that clears when read, a live view of the raw lines, a request register that clears when read, and a message target register.

A request is latched when an enabled line changes level, in either direction. A line that is already high when it becomes enabled latches nothing. The live view is there so that software can find lines that went high while they were masked. Software then writes the target register, and that write re-sends the message whenever an enabled line is still high.

A message goes out when the request register goes from empty to non-empty. Further changes that arrive while requests are still outstanding add request bits but send no new message. The message is held on `msg_valid` until `msg_ack` is seen.

Top module: `irq_concentrator`

## Requirements
- R1: While `rst_n` is low, and after reset until the first register write, the mask, pending and request registers read zero and `msg_valid` is low.
- R2: `reg_addr` selects registers as follows: 0 mask (read/write, bits 10:0), 1 pending, 2 live level, 3 request, 4 target (32 bits). `reg_rdata` shows the selected register in the same cycle that `reg_rd` is high, and reads zero when `reg_rd` is low or the address is unused. The live-level read always equals the current `irq_in`.
- R3: A change of level on an enabled line sets that line's pending bit and its request bit at the next clock edge. A change on a disabled line sets nothing.
- R4: Request bit 9 is not implemented and always reads zero. A change on line 9 sets only pending bit 9 and sends no message.
- R5: A request read returns the latched bits and clears them at the clock edge that ends the read. A change latched in that same cycle survives the clear.
- R6: A pending read clears the pending register only. The request register and the live level are unchanged.
- R7: Enabling a line that is already high latches no request and sends no message.
- R8: When the request register goes from empty to non-empty, `msg_valid` rises in the following cycle. `msg_addr` is the target with its low 5 bits cleared, and `msg_data` is the target's low 5 bits. A request read that clears the register in the same cycle as a new change counts as empty, so a message is sent.
- R9: Changes that arrive while the request register is non-empty send no further message. After the register has been cleared by a read, the next change sends a new message.
- R10: A write to the target register sends a message built from the written value when any enabled line is high at the time of the write. Otherwise the write sends nothing.
- R11: `msg_valid`, `msg_addr` and `msg_data` hold steady until a cycle with `msg_ack` high. A message that would start while one is still waiting is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 11 | Device interrupt lines, synchronous to clk |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| msg_valid | output | 1 | Interrupt message write request |
| msg_ack | input | 1 | Message write accepted |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The bench goes after several corner cases:

- A line that is high before it is enabled. A design that latches on level instead of change would raise a spurious request here.
- A falling edge on an enabled line. A rising-only detector would miss it.
- Line 9. A design that implements request bit 9 would send a message no software can decode.
- A request read that coincides with a new change. A design that compares against the stale register would drop that message, and one that clears after setting would lose the bit.
- A stalled acknowledge. A design that reloads the message outputs while the write is still waiting would corrupt the bus transaction.
- The retrigger write, both with an enabled line still high and with none high. A design that ignores it would leave a level-held device stranded, and one that fires regardless would send empty interrupts.

// File: rtl/irq_concentrator.sv
module irq_concentrator #(
  parameter int N_IRQ = 11,
  parameter logic [N_IRQ-1:0] REQ_IMPL = 11'h5FF,
  parameter int MSG_DATA_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             msg_valid,
  input  logic             msg_ack,
  output logic [31:0]      msg_addr,
  output logic [31:0]      msg_data
);
  localparam logic [2:0] A_MASK = 3'd0, A_PEND = 3'd1, A_LEVEL = 3'd2, A_REQ = 3'd3, A_TGT = 3'd4;
  localparam logic [31:0] DMASK = (32'd1 << MSG_DATA_W) - 32'd1;
  localparam int PADW = 32 - N_IRQ;

  logic [N_IRQ-1:0] mask_q, pend_q, req_q, prev_q;
  logic [31:0] tgt_q;

  wire rd_req  = reg_rd && reg_addr == A_REQ;
  wire rd_pend = reg_rd && reg_addr == A_PEND;
  wire wr_mask = reg_wr && reg_addr == A_MASK;
  wire wr_tgt  = reg_wr && reg_addr == A_TGT;

  wire [N_IRQ-1:0] edges    = (irq_in ^ prev_q) & mask_q;
  wire [N_IRQ-1:0] req_base = rd_req ? '0 : req_q;
  wire [N_IRQ-1:0] req_new  = edges & REQ_IMPL;
  wire retrig = wr_tgt && |(irq_in & mask_q);
  wire fire   = (req_base == '0 && req_new != '0) || retrig;
  wire busy   = msg_valid && !msg_ack;
  wire [31:0] tgt_src = wr_tgt ? reg_wdata : tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0; pend_q <= '0; req_q <= '0; prev_q <= '0; tgt_q <= '0;
      msg_valid <= 1'b0; msg_addr <= '0; msg_data <= '0;
    end else begin
      prev_q <= irq_in;
      req_q  <= req_base | req_new;
      pend_q <= (rd_pend ? '0 : pend_q) | edges;
      if (wr_mask) mask_q <= reg_wdata[N_IRQ-1:0];
      if (wr_tgt) tgt_q <= reg_wdata;
      if (fire && !busy) begin
        msg_valid <= 1'b1;
        msg_addr  <= tgt_src & ~DMASK;
        msg_data  <= tgt_src & DMASK;
      end else if (msg_ack) begin
        msg_valid <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_MASK:  reg_rdata = {{PADW{1'b0}}, mask_q};
        A_PEND:  reg_rdata = {{PADW{1'b0}}, pend_q};
        A_LEVEL: reg_rdata = {{PADW{1'b0}}, irq_in};
        A_REQ:   reg_rdata = {{PADW{1'b0}}, req_q};
        A_TGT:   reg_rdata = tgt_q;
        default: reg_rdata = '0;
      endcase
    end
  end

  assert_unimpl_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (reg_rdata[N_IRQ-1:0] & ~REQ_IMPL) == '0);

  assert_msg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ack) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0 && !rd_req) |=> $stable(req_q));

  assert_first_req_sends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|req_q) && !$past(msg_valid)) |-> msg_valid);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && ((irq_in ^ prev_q) & mask_q) == '0) |=> req_q == '0);
endmodule

// File: tb/tb_irq_concentrator.sv
module tb_irq_concentrator;
  logic clk = 0, rst_n = 0;
  logic [10:0] irq = '0;
  logic rd = 0, wr = 0, ack = 0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, maddr, mdata;
  logic mvalid;
  int compared = 0, mismatched = 0;
  bit done = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  irq_concentrator dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .reg_rd(rd), .reg_wr(wr),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .msg_valid(mvalid), .msg_ack(ack), .msg_addr(maddr), .msg_data(mdata));

  logic [10:0] m_mask, m_pend, m_req, m_prev, chg, base;
  logic [31:0] m_tgt, m_maddr, m_mdata, src;
  logic m_valid, fire;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 0; m_pend = 0; m_req = 0; m_prev = 0; m_tgt = 0;
      m_maddr = 0; m_mdata = 0; m_valid = 0;
    end else begin
      chg  = (irq ^ m_prev) & m_mask;
      base = (rd && addr == 3) ? 11'h0 : m_req;
      fire = (base == 0 && (chg & 11'h5FF) != 0) || (wr && addr == 4 && (irq & m_mask) != 0);
      src  = (wr && addr == 4) ? wdata : m_tgt;
      if (fire && !(m_valid && !ack)) begin
        m_valid = 1; m_maddr = {src[31:5], 5'b0}; m_mdata = {27'b0, src[4:0]};
      end else if (ack) m_valid = 0;
      m_pend = ((rd && addr == 1) ? 11'h0 : m_pend) | chg;
      m_req  = base | (chg & 11'h5FF);
      if (wr && addr == 0) m_mask = wdata[10:0];
      if (wr && addr == 4) m_tgt = wdata;
      m_prev = irq;
    end
  end

  function automatic logic [31:0] exp_rdata();
    if (!rd) return 0;
    case (addr)
      3'd0: return {21'b0, m_mask};
      3'd1: return {21'b0, m_pend};
      3'd2: return {21'b0, irq};
      3'd3: return {21'b0, m_req};
      3'd4: return m_tgt;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(logic [10:0] i, logic r, logic w, logic [2:0] a, logic [31:0] d, logic k);
    @(negedge clk);
    irq = i; rd = r; wr = w; addr = a; wdata = d; ack = k;
    #2;
    chk("rdata", rdata, exp_rdata());
    chk("msg_valid", {31'b0, mvalid}, {31'b0, m_valid});
    chk("msg_addr", maddr, m_maddr);
    chk("msg_data", mdata, m_mdata);
  endtask

  task automatic idle(logic [10:0] i, int n);
    for (int k = 0; k < n; k++) cyc(i, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    cyc(11'h7FF, 1, 0, 0, 0, 0);
    cyc(11'h7FF, 1, 0, 1, 0, 0);
    cyc(11'h7FF, 1, 0, 3, 0, 0);
    @(negedge clk); rst_n = 1;
    cyc(11'h000, 1, 0, 3, 0, 0);
    tag = "R2";
    cyc(11'h155, 1, 0, 2, 0, 0);
    cyc(11'h6AA, 1, 0, 2, 0, 0);
    cyc(11'h000, 1, 0, 7, 0, 0);
    cyc(11'h000, 0, 1, 4, 32'h8000_1A03, 0);
    cyc(11'h000, 1, 0, 4, 0, 0);
    tag = "R3";
    cyc(11'h001, 1, 0, 3, 0, 0);
    cyc(11'h000, 0, 1, 0, 32'h0000_07FF, 0);
    cyc(11'h000, 1, 0, 0, 0, 0);
    tag = "R8";
    cyc(11'h001, 0, 0, 0, 0, 0);
    cyc(11'h001, 1, 0, 3, 0, 0);
    tag = "R9";
    cyc(11'h003, 1, 0, 1, 0, 0);
    cyc(11'h003, 1, 0, 3, 0, 0);
    tag = "R5";
    cyc(11'h003, 1, 0, 3, 0, 1);
    idle(11'h003, 2);
    tag = "R3";
    cyc(11'h002, 1, 0, 3, 0, 0);
    cyc(11'h002, 1, 0, 3, 0, 1);
    tag = "R6";
    cyc(11'h002, 1, 0, 1, 0, 0);
    cyc(11'h002, 1, 0, 1, 0, 0);
    cyc(11'h002, 1, 0, 2, 0, 0);
    tag = "R4";
    cyc(11'h202, 1, 0, 3, 0, 0);
    cyc(11'h202, 1, 0, 3, 0, 0);
    cyc(11'h202, 1, 0, 1, 0, 0);
    tag = "R5";
    cyc(11'h206, 1, 0, 3, 0, 0);
    cyc(11'h206, 1, 0, 3, 0, 1);
    idle(11'h206, 2);
    tag = "R7";
    cyc(11'h206, 0, 1, 0, 32'h0000_0000, 0);
    cyc(11'h20E, 0, 0, 0, 0, 0);
    cyc(11'h20E, 0, 1, 0, 32'h0000_07FF, 0);
    idle(11'h20E, 2);
    cyc(11'h20E, 1, 0, 3, 0, 0);
    tag = "R10";
    cyc(11'h20E, 0, 1, 4, 32'h4000_2C1F, 0);
    cyc(11'h20E, 0, 0, 0, 0, 0);
    tag = "R11";
    cyc(11'h20E, 0, 1, 4, 32'h1234_5611, 0);
    cyc(11'h20F, 0, 0, 0, 0, 0);
    idle(11'h20F, 3);
    cyc(11'h20F, 1, 0, 3, 0, 1);
    idle(11'h20F, 2);
    tag = "R10";
    cyc(11'h20F, 0, 1, 0, 32'h0000_0000, 0);
    cyc(11'h20F, 0, 1, 4, 32'h0BAD_F00D, 0);
    idle(11'h20F, 2);
    tag = "R3";
    cyc(11'h000, 0, 0, 0, 0, 0);
    cyc(11'h000, 1, 0, 1, 0, 0);
    cyc(11'h000, 1, 0, 3, 0, 0);
    tag = "R8";
    for (int k = 0; k < 24; k++) begin
      cyc(11'((k * 37) & 11'h7FF), 0, (k % 8) == 0, 3'((k % 8) == 0 ? 0 : 0),
          32'h0000_05FF, (k % 3) == 0);
      cyc(11'((k * 37) & 11'h7FF), (k % 2) == 0, 0, 3'((k % 4) + 1), 0, (k % 5) == 0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule